// File: doc/BRIEF.md
# Quarter-Rate IF Digital Downconverter

This block turns a stream of real, signed 12-bit intermediate-frequency samples into complex baseband I/Q pairs. The carrier sits at exactly one quarter of each channel's sample rate, so the local oscillator reduces to a repeating pattern of +1, 0 and -1. Carrier removal therefore only passes a sample, zeroes it or negates it, and needs no multiplier or oscillator table. Each mixed branch then goes through a 7-tap symmetric low-pass FIR with fixed integer coefficients, which removes the image near half the sample rate. The output stream keeps every second sample of a channel.

Up to four antenna channels share one input stream, one sample per transfer, each transfer tagged with its channel number. The block keeps an oscillator phase and a FIR history for each channel, so channels may arrive in any order and with gaps.

Both streams use valid/ready handshakes. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. An output transfer happens where `out_valid` and `out_ready` are both high. The output stage holds one result. `in_ready` is high when that stage is empty or is being emptied in the same cycle. A result waiting under back-pressure stays unchanged until it is taken. A result appears one clock after the input transfer that produces it.

Top module: `ddc_fs4`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears `out_valid`, sets every channel's oscillator phase to 0 and clears every FIR history to zero.
- R2: The in-phase mixed value of a sample x is +x, 0, -x, 0 when the channel's phase is 0, 1, 2, 3.
- R3: The quadrature mixed value is 0, +x, 0, -x when the channel's phase is 0, 1, 2, 3. The zero products take part in the filter as zeros.
- R4: A channel's 2-bit phase goes up by one (modulo 4) on each accepted sample of that channel and on nothing else. The transfers of other channels leave it unchanged.
- R5: Each branch of each channel is filtered with coefficients -1, 0, 9, 16, 9, 0, -1. Coefficient k multiplies the mixed value accepted k samples earlier on that channel, where k=0 is the current sample.
- R6: An output is floor((acc + 2) / 4) of the full-precision sum, given as a 16-bit two's-complement value. Inputs over the whole range -2048..2047 never overflow it.
- R7: A result is produced only for an accepted sample whose phase is odd (1 or 3), which gives decimation by 2. `out_chan` carries that sample's channel. An accepted sample at an even phase produces no output.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i`, `out_q` and `out_chan` hold their values.
- R9: A sample offered while `in_ready` is low is not taken and changes no phase, history or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_chan | input | 2 | Channel number of the input sample |
| in_sample | input | 12 | Signed IF sample |
| out_valid | output | 1 | Baseband result present |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | 2 | Channel number of the result |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
On every cycle the assertions check the following. A channel's phase steps only on its own transfers. The branch that the oscillator pattern zeroes is zero when it enters the filter. A new result appears only after an odd-phase transfer. A stalled result stays frozen. The rounded sum always fits in 16 bits. The bench scenarios are needed for the arithmetic itself: the coefficient alignment against each channel's history, the rounding of negative sums, and the channels staying apart under interleaved and irregular traffic. They are also needed to show that reset clears the histories and that samples refused under random back-pressure leave no trace.

// File: rtl/ddc_fs4_pkg.sv
package ddc_fs4_pkg;

  localparam int TAPS   = 7;
  localparam int HALF   = TAPS / 2;
  // sum of |coefficients| is 36, below 2**6
  localparam int GROWTH = 6;

  typedef enum logic [1:0] {
    LO_P0   = 2'd0,
    LO_P90  = 2'd1,
    LO_P180 = 2'd2,
    LO_P270 = 2'd3
  } lo_phase_e;

  function automatic int tap_coef(input int k);
    case (k)
      0, 6:    return -1;
      1, 5:    return 0;
      2, 4:    return 9;
      3:       return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ddc_fs4_mixer.sv
module ddc_fs4_mixer
  import ddc_fs4_pkg::*;
#(
  parameter int IN_W = 12,
  localparam int MIX_W = IN_W + 1
) (
  input  logic [1:0]              phase,
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [MIX_W-1:0] mix_i,
  output logic signed [MIX_W-1:0] mix_q
);

  logic signed [MIX_W-1:0] ext;

  always_comb begin
    ext   = MIX_W'(sample);
    mix_i = '0;
    mix_q = '0;
    case (lo_phase_e'(phase))
      LO_P0:   mix_i = ext;
      LO_P90:  mix_q = ext;
      LO_P180: mix_i = -ext;
      LO_P270: mix_q = -ext;
      default: ;
    endcase
  end

endmodule

// File: rtl/ddc_fs4_chan_bank.sv
module ddc_fs4_chan_bank
  import ddc_fs4_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int MIX_W = 13,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HIST = TAPS - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CHW-1:0]            wr_chan,
  input  logic signed [MIX_W-1:0]   mix_i,
  input  logic signed [MIX_W-1:0]   mix_q,
  output logic [1:0]                sel_phase,
  output logic [HIST-1:0][MIX_W-1:0] sel_hist_i,
  output logic [HIST-1:0][MIX_W-1:0] sel_hist_q
);

  logic [1:0]              phase_r [NCH];
  logic signed [MIX_W-1:0] hist_i  [NCH][HIST];
  logic signed [MIX_W-1:0] hist_q  [NCH][HIST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        phase_r[c] <= '0;
        for (int j = 0; j < HIST; j++) begin
          hist_i[c][j] <= '0;
          hist_q[c][j] <= '0;
        end
      end
    end else if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_chan == CHW'(c)) begin
          phase_r[c]   <= phase_r[c] + 2'd1;
          hist_i[c][0] <= mix_i;
          hist_q[c][0] <= mix_q;
          for (int j = 1; j < HIST; j++) begin
            hist_i[c][j] <= hist_i[c][j-1];
            hist_q[c][j] <= hist_q[c][j-1];
          end
        end
      end
    end
  end

  always_comb begin
    sel_phase = phase_r[wr_chan];
    for (int j = 0; j < HIST; j++) begin
      sel_hist_i[j] = hist_i[wr_chan][j];
      sel_hist_q[j] = hist_q[wr_chan][j];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_phase_chk
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_chan == CHW'(g)) |=> (phase_r[g] == $past(phase_r[g]) + 2'd1))
      else $error("phase of channel %0d did not step", g); // R4
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_chan == CHW'(g)) |=> $stable(phase_r[g]))
      else $error("phase of channel %0d moved without its sample", g); // R4
  end

endmodule

// File: rtl/ddc_fs4_fir.sv
module ddc_fs4_fir
  import ddc_fs4_pkg::*;
#(
  parameter int MIX_W = 13,
  localparam int ACC_W = MIX_W + GROWTH
) (
  input  logic [TAPS-1:0][MIX_W-1:0] taps,
  output logic signed [ACC_W-1:0]    acc
);

  logic signed [ACC_W-1:0] prod [HALF+1];

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    logic signed [MIX_W:0] pair;
    assign pair    = $signed(taps[k]) + $signed(taps[TAPS-1-k]);
    assign prod[k] = ACC_W'(pair * tap_coef(k));
  end

  assign prod[HALF] = ACC_W'($signed(taps[HALF]) * tap_coef(HALF));

  always_comb begin
    acc = '0;
    for (int k = 0; k <= HALF; k++) acc = acc + prod[k];
  end

endmodule

// File: rtl/ddc_fs4.sv
module ddc_fs4
  import ddc_fs4_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int SHIFT = 2,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CHW-1:0]          in_chan,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CHW-1:0]          out_chan,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int MIX_W = IN_W + 1;
  localparam int ACC_W = MIX_W + GROWTH;
  localparam int HIST  = TAPS - 1;
  localparam logic signed [ACC_W-1:0] RND_BIAS = ACC_W'(1) <<< (SHIFT - 1);

  logic                          in_fire;
  logic [1:0]                    sel_phase;
  logic signed [MIX_W-1:0]       mix_i, mix_q;
  logic [HIST-1:0][MIX_W-1:0]    hist_i, hist_q;
  logic [TAPS-1:0][MIX_W-1:0]    taps_i, taps_q;
  logic signed [ACC_W-1:0]       acc_i, acc_q;
  logic signed [ACC_W-1:0]       rnd_i, rnd_q;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  ddc_fs4_chan_bank #(.NCH(NCH), .MIX_W(MIX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (in_fire),
    .wr_chan    (in_chan),
    .mix_i      (mix_i),
    .mix_q      (mix_q),
    .sel_phase  (sel_phase),
    .sel_hist_i (hist_i),
    .sel_hist_q (hist_q)
  );

  ddc_fs4_mixer #(.IN_W(IN_W)) u_mixer (
    .phase  (sel_phase),
    .sample (in_sample),
    .mix_i  (mix_i),
    .mix_q  (mix_q)
  );

  always_comb begin
    taps_i[0] = mix_i;
    taps_q[0] = mix_q;
    for (int k = 1; k < TAPS; k++) begin
      taps_i[k] = hist_i[k-1];
      taps_q[k] = hist_q[k-1];
    end
  end

  ddc_fs4_fir #(.MIX_W(MIX_W)) u_fir_i (.taps(taps_i), .acc(acc_i));
  ddc_fs4_fir #(.MIX_W(MIX_W)) u_fir_q (.taps(taps_q), .acc(acc_q));

  assign rnd_i = (acc_i + RND_BIAS) >>> SHIFT;
  assign rnd_q = (acc_q + RND_BIAS) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (in_fire && sel_phase[0]) begin
      out_valid <= 1'b1;
      out_chan  <= in_chan;
      out_i     <= rnd_i[OUT_W-1:0];
      out_q     <= rnd_q[OUT_W-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_chan)))
    else $error("stalled output changed"); // R8
  AST_DECIMATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire && sel_phase[0]))
    else $error("output without odd-phase sample"); // R7
  AST_ZERO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !sel_phase[0]) |-> (mix_q == '0))
    else $error("quadrature product not zero on even phase"); // R3
  AST_ZERO_I: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && sel_phase[0]) |-> (mix_i == '0))
    else $error("in-phase product not zero on odd phase"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (((&rnd_i[ACC_W-1:OUT_W-1]) || !(|rnd_i[ACC_W-1:OUT_W-1])) &&
                 ((&rnd_q[ACC_W-1:OUT_W-1]) || !(|rnd_q[ACC_W-1:OUT_W-1]))))
    else $error("rounded result exceeds output width"); // R6

endmodule

// File: tb/ddc_fs4_bench.sv
module ddc_fs4_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_chan = '0;
  logic signed [11:0] in_sample = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [1:0]        out_chan;
  logic signed [15:0] out_i, out_q;

  ddc_fs4 u_ddc_fs4 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_i(out_i), .out_q(out_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit bp_mode = 1'b0;
  bit m_fire = 1'b0;
  bit after_rst = 1'b0;

  // behavioural reference state
  int coef[7] = '{-1, 0, 9, 16, 9, 0, -1};
  int m_phase[NCH];
  int m_hi[NCH][7];
  int m_hq[NCH][7];
  bit m_valid;
  int m_i, m_q, m_chan;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_phase[c] = 0;
      for (int k = 0; k < 7; k++) begin
        m_hi[c][k] = 0;
        m_hq[c][k] = 0;
      end
    end
    m_valid = 0; m_i = 0; m_q = 0; m_chan = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_fire = 1'b0;
      after_rst = 1'b1;
    end else begin
      bit exp_ready, fire_out;
      if (after_rst) begin
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        after_rst = 1'b0;
      end
      exp_ready = !m_valid || out_ready;
      check(in_ready == exp_ready, "R8/R9 in_ready", int'(in_ready), int'(exp_ready));
      check(out_valid == m_valid, "R7/R8 out_valid", int'(out_valid), int'(m_valid));
      if (m_valid) begin
        check(int'(out_chan) == m_chan, "R4/R7 out_chan", int'(out_chan), m_chan);
        check(int'(out_i) == m_i, "R2/R5/R6 out_i", int'(out_i), m_i);
        check(int'(out_q) == m_q, "R3/R5/R6 out_q", int'(out_q), m_q);
      end
      fire_out = m_valid && out_ready;
      m_fire = in_valid && exp_ready;
      if (m_fire) begin
        int ch, x, ph, ai, aq;
        ch = int'(in_chan);
        x  = int'(in_sample);
        ph = m_phase[ch];
        for (int k = 6; k > 0; k--) begin
          m_hi[ch][k] = m_hi[ch][k-1];
          m_hq[ch][k] = m_hq[ch][k-1];
        end
        m_hi[ch][0] = (ph == 0) ? x : (ph == 2) ? -x : 0;
        m_hq[ch][0] = (ph == 1) ? x : (ph == 3) ? -x : 0;
        m_phase[ch] = (ph + 1) % 4;
        if (ph % 2 == 1) begin
          ai = 0; aq = 0;
          for (int k = 0; k < 7; k++) begin
            ai += coef[k] * m_hi[ch][k];
            aq += coef[k] * m_hq[ch][k];
          end
          m_valid = 1'b1;
          m_chan  = ch;
          m_i     = (ai + 2) >>> 2;
          m_q     = (aq + 2) >>> 2;
        end else if (fire_out) begin
          m_valid = 1'b0;
        end
      end else if (fire_out) begin
        m_valid = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // caller is at posedge + 1
  task automatic send(input int ch, input int x);
    in_valid  = 1'b1;
    in_chan   = 2'(ch);
    in_sample = 12'(x);
    forever begin
      @(posedge clk);
      if (m_fire) break;
    end
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic directed_r3();
    send(2, 1000);
    send(2, 500);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 directed valid", int'(out_valid), 1);
    check(int'(out_chan) == 2, "R7 directed chan", int'(out_chan), 2);
    check(int'(out_i) == 0, "R2 directed i", int'(out_i), 0);
    check(int'(out_q) == -125, "R3/R6 directed q", int'(out_q), -125);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    model_clear();
    @(posedge clk); #1;
    do_reset();

    // R3 directed odd-phase output on one channel
    directed_r3();

    // R5 single channel, constant input
    for (int n = 0; n < 40; n++) send(0, 300);
    idle(3);

    // R4 round robin over all channels
    for (int n = 0; n < 200; n++)
      for (int c = 0; c < NCH; c++) send(c, $urandom_range(0, 4095) - 2048);
    idle(3);

    // R8 R9 random back-pressure, irregular channel order and gaps
    bp_mode = 1'b1;
    for (int n = 0; n < 600; n++) begin
      send($urandom_range(0, 3), $urandom_range(0, 4095) - 2048);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    bp_mode = 1'b0;
    idle(4);

    // R6 full-scale extremes
    for (int n = 0; n < 300; n++)
      send(n % 2, ($urandom_range(0, 1) == 1) ? 2047 : -2048);
    for (int n = 0; n < 64; n++) send(3, ((n / 2) % 2 == 0) ? 2047 : -2048);
    idle(3);

    // R1 reset mid-stream clears phase and history
    send(2, 1234);
    send(1, -777);
    do_reset();
    directed_r3();
    idle(4);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule